// File: doc/BRIEF.md
# Sync Change Interrupt Controller

This block gathers six single-cycle event strobes from a sync-signal monitor into sticky flags. Each strobe reports a change in one property of the horizontal or the vertical sync: its presence, its polarity or its frequency. Two further strobes report that the horizontal or the vertical period counter has overflowed. An overflow sets the same flag as a frequency change on that sync signal.

Software writes an enable mask, and the block drives one active-low, level-sensitive interrupt request to a microcontroller core. The request is low while any flag is set together with its enable bit. The interrupt routine reads the flag byte to find the cause. It then writes a byte to the clear register: a 0 in a bit position clears that flag, and a 1 leaves it as it is. Because of this write-zero-to-clear rule, software can clear the flags it has handled and leave alone any flag that was set after the read.

Top module: `sync_evt_irq`

## Requirements
- R1: While reset is held, and right after it is released, every flag and every enable bit is 0, `rd_data` reads 0x00 and `irq_n` is 1.
- R2: A 1 on `evt_in[i]` sets flag i at the next rising clock edge, whether or not enable bit i is set. The flag order is: bit 0 horizontal presence, bit 1 vertical presence, bit 2 horizontal polarity, bit 3 vertical polarity, bit 4 horizontal frequency, bit 5 vertical frequency.
- R3: A 1 on `ovf_in[0]` (horizontal period overflow) sets flag 4. A 1 on `ovf_in[1]` (vertical period overflow) sets flag 5.
- R4: A flag that is set stays set until a clear write with a 0 in that flag's bit position.
- R5: A write with `wr_sel`=0 (clear register) clears every flag whose bit in `wr_data[5:0]` is 0. Flags whose bit is 1 keep their value.
- R6: If a flag's event or overflow strobe arrives in the same cycle as a clear of that flag, the flag is set after the edge.
- R7: A write with `wr_sel`=1 loads `wr_data[5:0]` into the enable mask. `irq_n` is 0 exactly when some flag i and enable bit i are both 1, and it follows a change of flags or mask in the same cycle that the change is registered.
- R8: `rd_data[5:0]` returns the current flags and `rd_data[7:6]` always reads 0.
- R9: Bits 7:6 of a clear write have no effect. An enable write does not change the flags, and a clear write does not change the enable mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_in | input | 6 | Single-cycle change strobes, one per flag, in flag order |
| ovf_in | input | 2 | Period-counter overflow strobes: bit 0 horizontal, bit 1 vertical |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 is the clear register, 1 is the enable register |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Flag byte; bits 7:6 are zero |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
A flag cell stuck low would show as a 0 in `rd_data` one cycle after its strobe. A flag cell that fails to hold would show as a bit that drops with no clear write. Either fault is visible at the read port on the first cycle it happens. The enable mask cannot be read back, so a wrong mask bit shows only through `irq_n`: the line stays high when it should be low, or goes low when it should stay high. It shows on the same cycle that the flag which exposes it is registered. The bench sets and clears single flags under several masks so that each enable bit and each flag is observed on its own.

// File: rtl/sc_pkg.sv
// Package sc_pkg
// Purpose : shared widths, flag positions and the write-target encoding
//           used by the sync change interrupt controller.
// Assumes : the six flags occupy the low bits of the register byte.
package sc_pkg;
    parameter int FLAG_W = 6;
    parameter int REG_W  = 8;
    parameter int OVF_W  = 2;

    // Flag bit positions, in the order software decodes them
    parameter int F_H_PRES = 0;
    parameter int F_V_PRES = 1;
    parameter int F_H_POL  = 2;
    parameter int F_V_POL  = 3;
    parameter int F_H_FREQ = 4;
    parameter int F_V_FREQ = 5;

    // Register selected by a write
    typedef enum logic {
        SEL_CLEAR  = 1'b0,
        SEL_ENABLE = 1'b1
    } wr_target_e;
endpackage

// File: rtl/sc_set_merge.sv
// Module sc_set_merge
// Purpose : folds the period-overflow strobes into the frequency-change
//           strobes, so that each flag has a single set request.
// Assumes : strobes last one cycle; ovf_in[0] is horizontal and
//           ovf_in[1] is vertical.
module sc_set_merge
    import sc_pkg::*;
(
    input  logic [FLAG_W-1:0] evt_in,
    input  logic [OVF_W-1:0]  ovf_in,
    output logic [FLAG_W-1:0] set_req
);
    // Build the per-flag set request vector
    always_comb begin
        set_req           = evt_in;
        set_req[F_H_FREQ] = evt_in[F_H_FREQ] | ovf_in[0];
        set_req[F_V_FREQ] = evt_in[F_V_FREQ] | ovf_in[1];
    end
endmodule

// File: rtl/sc_reg_port.sv
// Module sc_reg_port
// Purpose : decodes register writes into a per-flag clear request and
//           holds the interrupt enable mask.
// Assumes : a write lasts one cycle; a 0 in the clear register clears
//           a flag and a 1 leaves it; bits above the flag field are
//           ignored by both registers.
module sc_reg_port
    import sc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [REG_W-1:0]  wr_data,
    output logic [FLAG_W-1:0] clr_req,
    output logic [FLAG_W-1:0] en_mask
);
    localparam int SPARE_W = REG_W - FLAG_W;

    logic [SPARE_W-1:0] unused_hi;
    wr_target_e         target;

    assign unused_hi = wr_data[REG_W-1:FLAG_W];
    assign target    = wr_target_e'(wr_sel);

    // Turn zero bits of a clear-register write into clear requests
    always_comb begin
        clr_req = '0;
        if (wr_en && target == SEL_CLEAR)
            clr_req = ~wr_data[FLAG_W-1:0];
    end

    // Hold the enable mask, loaded by an enable-register write
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_mask <= '0;
        else if (wr_en && target == SEL_ENABLE)
            en_mask <= wr_data[FLAG_W-1:0];
    end
endmodule

// File: rtl/sc_flag_bank.sv
// Module sc_flag_bank
// Purpose : one sticky flag per source; a set request takes priority
//           over a clear request that arrives in the same cycle.
// Assumes : synchronous active-low reset clears every flag.
module sc_flag_bank
    import sc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] set_req,
    input  logic [FLAG_W-1:0] clr_req,
    output logic [FLAG_W-1:0] flags
);
    for (genvar i = 0; i < FLAG_W; i++) begin : g_cell
        // Sticky cell: a set wins, a clear drops the flag, otherwise it holds
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags[i] <= 1'b0;
            else if (set_req[i])
                flags[i] <= 1'b1;
            else if (clr_req[i])
                flags[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/sc_irq_combine.sv
// Module sc_irq_combine
// Purpose : masks the flags with the enable bits and forms the
//           active-low request.
// Assumes : both inputs come straight from registers, so the output is
//           glitch-free within a cycle.
module sc_irq_combine
    import sc_pkg::*;
(
    input  logic [FLAG_W-1:0] flags,
    input  logic [FLAG_W-1:0] en_mask,
    output logic              irq_n
);
    logic [FLAG_W-1:0] pending;

    // The request is low while any enabled flag is pending
    always_comb begin
        pending = flags & en_mask;
        irq_n   = ~(|pending);
    end
endmodule

// File: rtl/sync_evt_irq.sv
// Module sync_evt_irq
// Purpose : top of the sync change interrupt controller. Collects the
//           change and overflow strobes into sticky flags, decodes
//           register writes and drives one active-low interrupt line.
// Assumes : strobes and writes last one cycle; the flag byte is read
//           combinationally from the flag registers.
module sync_evt_irq
    import sc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] evt_in,
    input  logic [OVF_W-1:0]  ovf_in,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    output logic              irq_n
);
    localparam int SPARE_W = REG_W - FLAG_W;

    logic [FLAG_W-1:0] set_req;
    logic [FLAG_W-1:0] clr_req;
    logic [FLAG_W-1:0] en_mask;
    logic [FLAG_W-1:0] flags;

    sc_set_merge u_merge (
        .evt_in  (evt_in),
        .ovf_in  (ovf_in),
        .set_req (set_req)
    );

    sc_reg_port u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .clr_req (clr_req),
        .en_mask (en_mask)
    );

    sc_flag_bank u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (set_req),
        .clr_req (clr_req),
        .flags   (flags)
    );

    sc_irq_combine u_irq (
        .flags   (flags),
        .en_mask (en_mask),
        .irq_n   (irq_n)
    );

    // Present the flags in the low bits of the read byte, upper bits zero
    always_comb begin
        rd_data = {{SPARE_W{1'b0}}, flags};
    end
endmodule

// File: rtl/sc_checker.sv
// Module sc_checker
// Purpose : port-level properties of the sync change interrupt
//           controller, bound to every instance of the top module.
// Assumes : the same parameters as the top module, taken from sc_pkg.
module sc_checker
    import sc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [FLAG_W-1:0] evt_in,
    input logic [OVF_W-1:0]  ovf_in,
    input logic              wr_en,
    input logic              wr_sel,
    input logic [REG_W-1:0]  wr_data,
    input logic [REG_W-1:0]  rd_data,
    input logic              irq_n
);
    logic [FLAG_W-1:0] any_set;
    logic [FLAG_W-1:0] clr_bit;

    always_comb begin
        any_set           = evt_in;
        any_set[F_H_FREQ] = evt_in[F_H_FREQ] | ovf_in[0];
        any_set[F_V_FREQ] = evt_in[F_V_FREQ] | ovf_in[1];
        clr_bit           = (wr_en && !wr_sel) ? ~wr_data[FLAG_W-1:0] : '0;
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (rd_data == '0 && irq_n));

    assert_ovf_h_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_in[0] |=> rd_data[F_H_FREQ]);

    assert_ovf_v_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_in[1] |=> rd_data[F_V_FREQ]);

    assert_request_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (rd_data[FLAG_W-1:0] != '0));

    assert_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[REG_W-1:FLAG_W] == '0);

    for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
        assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
            evt_in[i] |=> rd_data[i]);

        assert_flag_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_data[i] && !clr_bit[i]) |=> rd_data[i]);

        assert_clear_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_bit[i] && !any_set[i]) |=> !rd_data[i]);

        assert_set_beats_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_bit[i] && any_set[i]) |=> rd_data[i]);
    end
endmodule

bind sync_evt_irq sc_checker u_chk (.*);

// File: tb/sim_sync_evt_irq.sv
module sim_sync_evt_irq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] evt_in = '0;
    logic [1:0] ovf_in = '0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       irq_n;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    sync_evt_irq u0 (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .ovf_in(ovf_in),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_data(rd_data), .irq_n(irq_n)
    );

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    // Apply one cycle of stimulus; on return the edge has captured it
    task automatic cycle(input logic [5:0] ev, input logic [1:0] ov,
                         input logic we, input logic sel, input logic [7:0] d);
        evt_in = ev; ovf_in = ov; wr_en = we; wr_sel = sel; wr_data = d;
        @(negedge clk);
        evt_in = '0; ovf_in = '0; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R1", "flags in reset", rd_data, 8'h00);
        check("R1", "irq in reset", {7'b0, irq_n}, 8'h01);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "flags after reset", rd_data, 8'h00);
        // the enable mask must also be cleared: a flag alone gives no request
        cycle(6'h3F, 2'b00, 1'b0, 1'b0, 8'h00);
        check("R1", "enables zero after reset", {7'b0, irq_n}, 8'h01);
    endtask

    task automatic t_events();
        do_reset();
        for (int i = 0; i < 6; i++) begin
            cycle(6'(1 << i), 2'b00, 1'b0, 1'b0, 8'h00);
            check("R2", $sformatf("flag %0d set while disabled", i),
                  rd_data, 8'((1 << (i + 1)) - 1));
            check("R2", "irq stays high with mask zero", {7'b0, irq_n}, 8'h01);
        end
    endtask

    task automatic t_overflow();
        do_reset();
        cycle(6'h00, 2'b01, 1'b0, 1'b0, 8'h00);
        check("R3", "h overflow sets bit 4", rd_data, 8'h10);
        cycle(6'h00, 2'b10, 1'b0, 1'b0, 8'h00);
        check("R3", "v overflow sets bit 5", rd_data, 8'h30);
    endtask

    task automatic t_hold();
        do_reset();
        cycle(6'h05, 2'b00, 1'b0, 1'b0, 8'h00);
        repeat (10) @(negedge clk);
        check("R4", "flags hold with no clear", rd_data, 8'h05);
        cycle(6'h00, 2'b00, 1'b1, 1'b0, 8'hFF);
        check("R4", "all-ones clear leaves flags", rd_data, 8'h05);
    endtask

    task automatic t_clear();
        do_reset();
        cycle(6'h3F, 2'b00, 1'b0, 1'b0, 8'h00);
        cycle(6'h00, 2'b00, 1'b1, 1'b0, 8'hFE);
        check("R5", "clear bit 0 only", rd_data, 8'h3E);
        cycle(6'h00, 2'b00, 1'b1, 1'b0, 8'hEB);
        check("R5", "clear bits 2 and 4", rd_data, 8'h2A);
        cycle(6'h00, 2'b00, 1'b1, 1'b0, 8'hC0);
        check("R5", "clear all", rd_data, 8'h00);
    endtask

    task automatic t_collision();
        do_reset();
        cycle(6'h02, 2'b00, 1'b1, 1'b0, 8'h00);
        check("R6", "event beats clear on bit 1", rd_data, 8'h02);
        cycle(6'h00, 2'b10, 1'b1, 1'b0, 8'hDF);
        check("R6", "overflow beats clear on bit 5", rd_data, 8'h22);
    endtask

    task automatic t_mask();
        do_reset();
        cycle(6'h00, 2'b00, 1'b1, 1'b1, 8'h08);
        check("R7", "mask only, no flag", {7'b0, irq_n}, 8'h01);
        cycle(6'h04, 2'b00, 1'b0, 1'b0, 8'h00);
        check("R7", "unmasked flag 2", {7'b0, irq_n}, 8'h01);
        cycle(6'h08, 2'b00, 1'b0, 1'b0, 8'h00);
        check("R7", "enabled flag 3 asserts", {7'b0, irq_n}, 8'h00);
        cycle(6'h00, 2'b00, 1'b1, 1'b1, 8'h04);
        check("R7", "mask moved to set flag 2", {7'b0, irq_n}, 8'h00);
        cycle(6'h00, 2'b00, 1'b1, 1'b0, 8'hFB);
        check("R7", "clearing flag 2 releases", {7'b0, irq_n}, 8'h01);
        check("R9", "enable write kept flags", rd_data, 8'h08);
        cycle(6'h00, 2'b00, 1'b1, 1'b1, 8'h00);
        check("R7", "mask cleared", {7'b0, irq_n}, 8'h01);
    endtask

    task automatic t_upper();
        do_reset();
        cycle(6'h3F, 2'b00, 1'b0, 1'b0, 8'h00);
        check("R8", "all flags, upper zero", rd_data, 8'h3F);
        cycle(6'h00, 2'b00, 1'b1, 1'b0, 8'h3F);
        check("R9", "upper clear bits ignored", rd_data, 8'h3F);
        cycle(6'h00, 2'b00, 1'b1, 1'b1, 8'hC1);
        check("R9", "enable write keeps flags", rd_data, 8'h3F);
        check("R9", "enable bit 0 loaded", {7'b0, irq_n}, 8'h00);
        cycle(6'h00, 2'b00, 1'b1, 1'b0, 8'hFE);
        check("R9", "clear write kept the mask", {7'b0, irq_n}, 8'h01);
        cycle(6'h01, 2'b00, 1'b0, 1'b0, 8'h00);
        check("R9", "mask still set after clear", {7'b0, irq_n}, 8'h00);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_events();
        t_overflow();
        t_hold();
        t_clear();
        t_collision();
        t_mask();
        t_upper();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule